// File: doc/BRIEF.md
# Fast/Slow Pile-Up Rejector

This block sits after two parallel digital shapers. One is a short fast channel that marks when events arrive. The other is the long slow main channel whose peak height measures event energy. Both sample streams arrive together, one sample per cycle in which `smp_valid` is high. Each channel is compared against its own programmable signed threshold.

Every rising crossing of the fast threshold is a fast trigger, and each trigger adds one to a saturating incoming-count counter. A slow pulse is the run of valid samples at or above the slow threshold. The block tracks the largest sample in that run. When the run ends, the block decides whether to keep the event. If two or more fast triggers fell in the first `peak_time` samples of the pulse, the event is piled up. With rejection enabled, a piled-up event gives a reject strobe; otherwise it gives an accept strobe carrying the peak. The only dead time is the pulse itself: the block adds none for capturing the peak.

The block is always ready and applies no back-pressure. A sample is consumed on every clock edge where `smp_valid` is high, and samples without it have no effect. Results are single-cycle strobes without a ready, so a downstream histogram must take them as they come.

Top module: `fsp_pileup_rej`

## Requirements
- R1: A fast trigger occurs on a valid sample with `fast_smp >= fast_thr` (signed) while the trigger is armed. Arming is lost on that sample and returns only after a valid sample with `fast_smp < fast_thr`. The trigger is armed after reset.
- R2: Each fast trigger raises `icr_cnt` by one on the same clock edge, whether or not the event is later accepted. `icr_cnt` is 0 after reset.
- R3: `icr_cnt` (CNT_W bits, default 32) saturates at its all-ones value.
- R4: `icr_clr` clears `icr_cnt` to 0 on the next edge and takes priority over a trigger on that edge.
- R5: A slow pulse starts on a valid sample with `slow_smp >= slow_thr` and ends on the first later valid sample below it. The reported peak is the largest sample of the pulse.
- R6: Exactly one result strobe, lasting one cycle, is driven in the cycle after the edge that takes the ending sample. A run of samples that never reaches `slow_thr` produces no strobe. A new pulse may start on the very next valid sample.
- R7: A fast trigger is counted for a pulse when it occurs on a sample whose index within the pulse is below `peak_time`, with index 0 being the starting sample. If `pur_en` is high on the ending sample and two or more triggers were counted, `rej_valid` pulses and `acc_valid` does not.
- R8: A fast trigger at a pulse index of `peak_time` or more is not counted toward pile-up.
- R9: With `pur_en` low on the ending sample, the event is accepted however many triggers occurred.
- R10: Cycles with `smp_valid` low change neither the trigger arming, the counter, nor the pulse state.
- R11: `acc_valid` and `rej_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Both channel samples are present this cycle |
| fast_smp | input | SAMPLE_W | Fast channel sample, signed |
| slow_smp | input | SAMPLE_W | Slow channel sample, signed |
| fast_thr | input | SAMPLE_W | Fast channel threshold, signed |
| slow_thr | input | SAMPLE_W | Slow channel threshold, signed |
| peak_time | input | PT_W | Pile-up window length in samples |
| pur_en | input | 1 | Enable pile-up rejection |
| icr_clr | input | 1 | Synchronous clear of the count |
| acc_valid | output | 1 | Accepted event strobe |
| acc_peak | output | SAMPLE_W | Peak of the accepted event, valid with acc_valid |
| rej_valid | output | 1 | Rejected (piled-up) event strobe |
| icr_cnt | output | CNT_W | Incoming fast trigger count |

## Verification
The count moves on the same edge that takes a triggering sample, so it is visible one cycle after that sample is presented. The accept or reject strobe and its peak appear one cycle after the pulse's ending sample, because the decision passes through one output register. The bench drives inputs on the falling edge. A behavioural model advances on each rising edge and holds its predictions in that same register stage. Outputs are compared with the model on every falling edge, and each scenario is closed with a few idle cycles before its tallied strobes and count are checked against hand-derived values.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  typedef enum logic {
    SLOW_IDLE = 1'b0,
    SLOW_BUSY = 1'b1
  } slow_state_t;

  localparam int TRIG_CNT_W = 2;
endpackage

// File: rtl/fsp_fast_trig.sv
module fsp_fast_trig #(
  parameter int SAMPLE_W = 16,
  parameter int CNT_W    = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       smp_valid,
  input  logic signed [SAMPLE_W-1:0] fast_smp,
  input  logic signed [SAMPLE_W-1:0] fast_thr,
  input  logic                       icr_clr,
  output logic                       trig,
  output logic [CNT_W-1:0]           icr_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic armed;
  logic over;

  assign over = (fast_smp >= fast_thr);
  assign trig = smp_valid && armed && over;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b1;
    end else if (smp_valid) begin
      armed <= !over;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icr_cnt <= '0;
    end else if (icr_clr) begin
      icr_cnt <= '0;
    end else if (trig && (icr_cnt != CNT_MAX)) begin
      icr_cnt <= icr_cnt + 1'b1;
    end
  end

  AST_TRIG_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !trig); // R1
  AST_ICR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    icr_clr |=> (icr_cnt == '0)); // R4
  AST_ICR_HOLD_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    (icr_cnt == CNT_MAX && !icr_clr) |=> (icr_cnt == CNT_MAX)); // R3
  AST_ICR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !icr_clr |=> (icr_cnt == $past(icr_cnt) || icr_cnt == $past(icr_cnt) + 1'b1)); // R2
endmodule

// File: rtl/fsp_slow_peak.sv
module fsp_slow_peak
  import fsp_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int PT_W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       smp_valid,
  input  logic signed [SAMPLE_W-1:0] slow_smp,
  input  logic signed [SAMPLE_W-1:0] slow_thr,
  input  logic [PT_W-1:0]            peak_time,
  input  logic                       fast_trig,
  output logic                       fin,
  output logic signed [SAMPLE_W-1:0] fin_peak,
  output logic                       fin_pile
);
  localparam logic [PT_W-1:0]       AGE_MAX  = '1;
  localparam logic [TRIG_CNT_W-1:0] NTRIG_MAX = '1;

  slow_state_t                state;
  logic signed [SAMPLE_W-1:0] peak;
  logic [PT_W-1:0]            age;
  logic [TRIG_CNT_W-1:0]      ntrig;
  logic                       above;
  logic                       in_win;

  assign above    = (slow_smp >= slow_thr);
  assign in_win   = (state == SLOW_IDLE) ? (peak_time != '0) : (age < peak_time);
  assign fin      = smp_valid && (state == SLOW_BUSY) && !above;
  assign fin_peak = peak;
  assign fin_pile = (ntrig >= TRIG_CNT_W'(2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SLOW_IDLE;
      peak  <= '0;
      age   <= '0;
      ntrig <= '0;
    end else if (smp_valid) begin
      case (state)
        SLOW_IDLE: begin
          if (above) begin
            state <= SLOW_BUSY;
            peak  <= slow_smp;
            age   <= PT_W'(1);
            ntrig <= (fast_trig && in_win) ? TRIG_CNT_W'(1) : '0;
          end
        end
        default: begin
          if (above) begin
            if (slow_smp > peak) peak <= slow_smp;
            if (age != AGE_MAX) age <= age + 1'b1;
            if (fast_trig && in_win && (ntrig != NTRIG_MAX)) ntrig <= ntrig + 1'b1;
          end else begin
            state <= SLOW_IDLE;
          end
        end
      endcase
    end
  end

  AST_PEAK_HELD_IDLE_SMP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SLOW_BUSY && !smp_valid) |=> $stable(peak)); // R10
endmodule

// File: rtl/fsp_pileup_rej.sv
module fsp_pileup_rej #(
  parameter int SAMPLE_W = 16,
  parameter int CNT_W    = 32,
  parameter int PT_W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       smp_valid,
  input  logic signed [SAMPLE_W-1:0] fast_smp,
  input  logic signed [SAMPLE_W-1:0] slow_smp,
  input  logic signed [SAMPLE_W-1:0] fast_thr,
  input  logic signed [SAMPLE_W-1:0] slow_thr,
  input  logic [PT_W-1:0]            peak_time,
  input  logic                       pur_en,
  input  logic                       icr_clr,
  output logic                       acc_valid,
  output logic signed [SAMPLE_W-1:0] acc_peak,
  output logic                       rej_valid,
  output logic [CNT_W-1:0]           icr_cnt
);
  logic                       trig;
  logic                       fin;
  logic signed [SAMPLE_W-1:0] fin_peak;
  logic                       fin_pile;
  logic                       drop;

  fsp_fast_trig #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_fast (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .fast_smp(fast_smp), .fast_thr(fast_thr), .icr_clr(icr_clr),
    .trig(trig), .icr_cnt(icr_cnt)
  );

  fsp_slow_peak #(.SAMPLE_W(SAMPLE_W), .PT_W(PT_W)) u_slow (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .slow_smp(slow_smp), .slow_thr(slow_thr), .peak_time(peak_time),
    .fast_trig(trig), .fin(fin), .fin_peak(fin_peak), .fin_pile(fin_pile)
  );

  assign drop = pur_en && fin_pile;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_valid <= 1'b0;
      rej_valid <= 1'b0;
      acc_peak  <= '0;
    end else begin
      acc_valid <= fin && !drop;
      rej_valid <= fin && drop;
      if (fin) acc_peak <= fin_peak;
    end
  end

  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid && rej_valid)); // R11
  AST_RESULT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid || rej_valid) |=> !(acc_valid || rej_valid)); // R6
  AST_REJ_NEEDS_PUR: assert property (@(posedge clk) disable iff (!rst_n)
    rej_valid |-> $past(pur_en)); // R9
endmodule

// File: tb/fsp_pileup_rej_bench.sv
`timescale 1ns/1ps
module fsp_pileup_rej_bench;
  localparam int SW = 16;
  localparam int CW = 4;
  localparam int PW = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic signed [SW-1:0] fast_smp = '0, slow_smp = '0;
  logic signed [SW-1:0] fast_thr = 16'sd100, slow_thr = 16'sd200;
  logic [PW-1:0] peak_time = 8'd4;
  logic pur_en = 1'b1, icr_clr = 1'b0;
  logic acc_valid, rej_valid;
  logic signed [SW-1:0] acc_peak;
  logic [CW-1:0] icr_cnt;

  always #2.5 clk = ~clk;

  fsp_pileup_rej #(.SAMPLE_W(SW), .CNT_W(CW), .PT_W(PW)) u_fsp_pileup_rej (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
    .fast_smp(fast_smp), .slow_smp(slow_smp), .fast_thr(fast_thr), .slow_thr(slow_thr),
    .peak_time(peak_time), .pur_en(pur_en), .icr_clr(icr_clr),
    .acc_valid(acc_valid), .acc_peak(acc_peak), .rej_valid(rej_valid), .icr_cnt(icr_cnt)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit m_armed, m_busy;
  int m_icr, m_peak, m_idx, m_ntrig;
  bit e_acc, e_rej;
  int e_peak;

  always @(posedge clk) begin
    bit t;
    if (!rst_n) begin
      m_armed = 1; m_busy = 0; m_icr = 0; m_peak = 0; m_idx = 0; m_ntrig = 0;
      e_acc = 0; e_rej = 0;
    end else begin
      e_acc = 0; e_rej = 0;
      t = smp_valid && m_armed && (int'(fast_smp) >= int'(fast_thr));
      if (icr_clr) m_icr = 0;
      else if (t && m_icr < CMAX) m_icr++;
      if (smp_valid) begin
        m_armed = int'(fast_smp) < int'(fast_thr);
        if (!m_busy) begin
          if (int'(slow_smp) >= int'(slow_thr)) begin
            m_busy = 1; m_peak = slow_smp; m_idx = 1;
            m_ntrig = (t && peak_time > 0) ? 1 : 0;
          end
        end else if (int'(slow_smp) >= int'(slow_thr)) begin
          if (int'(slow_smp) > m_peak) m_peak = slow_smp;
          if (t && m_idx < int'(peak_time)) m_ntrig++;
          m_idx++;
        end else begin
          m_busy = 0;
          if (pur_en && m_ntrig >= 2) e_rej = 1;
          else begin e_acc = 1; e_peak = m_peak; end
        end
      end
    end
  end

  // per-cycle comparison and strobe tally
  int acc_seen = 0, rej_seen = 0, last_peak = 0;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(acc_valid == e_acc, "R6 accept strobe vs model", acc_valid, e_acc);
      chk(rej_valid == e_rej, "R7 reject strobe vs model", rej_valid, e_rej);
      chk(int'(icr_cnt) == m_icr, "R2 count vs model", icr_cnt, m_icr);
      chk(!(acc_valid && rej_valid), "R11 exclusive strobes", acc_valid, 0);
      if (e_acc) chk(int'(acc_peak) == e_peak, "R5 peak vs model", acc_peak, e_peak);
      if (acc_valid) begin acc_seen++; last_peak = acc_peak; end
      if (rej_valid) rej_seen++;
    end
  end

  task automatic send(input int f, input int s);
    @(negedge clk);
    smp_valid = 1'b1; fast_smp = SW'(f); slow_smp = SW'(s);
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_valid = 1'b0;
    end
  endtask

  int icr0;
  task automatic start_scn();
    @(negedge clk);
    acc_seen = 0; rej_seen = 0; icr0 = icr_cnt;
  endtask

  task automatic end_scn(input string tag, input int acc_e, input int rej_e, input int d_icr);
    gap(3);
    chk(acc_seen == acc_e, {tag, " accepts"}, acc_seen, acc_e);
    chk(rej_seen == rej_e, {tag, " rejects"}, rej_seen, rej_e);
    chk(int'(icr_cnt) - icr0 == d_icr, {tag, " count delta"}, int'(icr_cnt) - icr0, d_icr);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(acc_valid == 0 && rej_valid == 0, "R6 reset strobes low", acc_valid | rej_valid, 0);
    chk(icr_cnt == 0, "R2 reset count zero", icr_cnt, 0);
    rst_n = 1'b1;

    // single clean pulse
    start_scn();
    send(150, 250); send(50, 300); send(50, 280); send(50, 100);
    end_scn("R5 single pulse", 1, 0, 1);
    chk(last_peak == 300, "R5 peak value", last_peak, 300);

    // two triggers inside window, rejection on
    start_scn();
    send(150, 250); send(50, 260); send(150, 400); send(50, 300); send(50, 0);
    end_scn("R7 piled-up rejected", 0, 1, 2);

    // same, rejection off
    pur_en = 1'b0;
    start_scn();
    send(150, 250); send(50, 260); send(150, 400); send(50, 300); send(50, 0);
    end_scn("R9 pur off accepts", 1, 0, 2);
    chk(last_peak == 400, "R9 peak value", last_peak, 400);
    pur_en = 1'b1;

    // second trigger at index 5, beyond window of 4
    start_scn();
    send(150, 250); send(50, 260); send(50, 270); send(50, 280); send(50, 290);
    send(150, 500); send(50, 0);
    end_scn("R8 late trigger ignored", 1, 0, 2);
    chk(last_peak == 500, "R8 peak value", last_peak, 500);

    // slow never reaches threshold
    start_scn();
    send(150, 150); send(50, 199); send(50, 0);
    end_scn("R6 sub-threshold no strobe", 0, 0, 1);

    // fast held high triggers once until it drops
    start_scn();
    send(150, 50); send(150, 50); send(150, 50); send(50, 50); send(150, 50);
    end_scn("R1 re-arm", 0, 0, 2);

    // invalid samples ignored
    start_scn();
    send(50, 0);
    @(negedge clk);
    smp_valid = 1'b0; fast_smp = 16'sd500; slow_smp = 16'sd500;
    repeat (5) @(negedge clk);
    chk(acc_seen == 0 && rej_seen == 0, "R10 no strobe on invalid", acc_seen + rej_seen, 0);
    chk(int'(icr_cnt) == icr0, "R10 count held on invalid", icr_cnt, icr0);
    send(50, 0);
    end_scn("R10 after invalid", 0, 0, 0);

    // back-to-back pulses, no dead time
    start_scn();
    send(150, 250); send(50, 0); send(150, 300); send(50, 0);
    end_scn("R6 back-to-back", 2, 0, 2);

    // saturation
    start_scn();
    for (int i = 0; i < 20; i++) begin send(150, 0); send(50, 0); end
    gap(2);
    chk(icr_cnt == CMAX, "R3 saturated count", icr_cnt, CMAX);

    // clear wins over a trigger on the same edge
    @(negedge clk);
    smp_valid = 1'b1; fast_smp = 16'sd150; slow_smp = '0; icr_clr = 1'b1;
    @(negedge clk);
    icr_clr = 1'b0; smp_valid = 1'b0;
    chk(icr_cnt == 0, "R4 clear beats trigger", icr_cnt, 0);
    send(50, 0); send(150, 0);
    gap(2);
    chk(icr_cnt == 1, "R4 counts after clear", icr_cnt, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule